// File: doc/BRIEF.md
# Protected Cache Tag Hit Detector

This unit finds the matching way of a set-associative cache whose stored tags carry check bits against soft errors. On each lookup the tag of the incoming address is encoded once. One build parameter chooses the code: a single even-parity bit, or Hamming single-error-correction bits. The fresh codeword is then compared, in parallel, with the stored codeword of every way. The per-way paths only XOR the two codewords and classify how many bits differ. They do not recompute parity or decode a syndrome.

In correction mode, a way whose stored codeword is one bit away from the fresh codeword still hits, and the error flag is raised so the line can be scrubbed. In parity mode, a one-bit difference is a detected error and is treated as a miss. The outputs are a hit vector, an any-hit flag, the index of the hitting way and the error flag. An optional register stage, on by default, delays all of them by one clock.

Top module: `tag_guard_cmp`

## Requirements
- R1: In correction mode the codeword is {check[r-1:0], tag}, with the tag in the low bits. r is the smallest value with 2^r >= TAG_W + r + 1, which gives r = 5 for a 20-bit tag. Tag bit d takes the d-th Hamming position that is not a power of two, counting from position 3 upward. Check bit j (codeword bit TAG_W + j) is the XOR of the tag bits whose position has bit j set.
- R2: In parity mode the codeword is {p, tag}, where p is bit TAG_W and equals the XOR of all tag bits.
- R3: In correction mode, a valid way hits when its stored codeword differs from the fresh codeword in zero or one bit.
- R4: In correction mode, err_o is high when a valid way differs in exactly one bit, and low when every valid way either matches exactly or differs in two or more bits.
- R5: In parity mode, a valid way hits only on an exact match. A one-bit difference gives no hit and raises err_o.
- R6: In both modes, a difference of two or more bits gives neither a hit nor err_o.
- R7: A way whose valid bit is low never hits and never raises err_o, whatever it stores.
- R8: hit_any_o is the OR of hit_vec_o. hit_idx_o is the lowest-numbered hitting way, and 0 when no way hits.
- R9: With the output register enabled, every output shows the result for the inputs of the previous rising clock. While rst_ni is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lookup_tag_i | input | TAG_W | Tag field of the lookup address |
| way_cw_i | input | WAYS x CW_W | Stored codeword of each way |
| valid_i | input | WAYS | Valid bit of each way |
| hit_vec_o | output | WAYS | Per-way hit |
| hit_any_o | output | 1 | Some way hit |
| hit_idx_o | output | IDX_W | Lowest hitting way |
| err_o | output | 1 | A valid way differs in exactly one bit |

## Verification
In correction mode, a hit and an error report occur in the same cycle whenever the matching way holds a codeword with one flipped bit. The bench provokes this with fixed flips in both tag bits and check bits, and with random single-bit faults on random ways. Each such lookup must report the correct way with err_o high. The same stimulus goes at the same time to a parity-mode instance, which must show a miss with err_o high. Two-bit faults, faults in invalid ways and a duplicated tag test the edges where hit and error must both stay low, or where the lowest way must win.

// File: rtl/tag_guard_pkg.sv
package tag_guard_pkg;
  // check-bit count for the chosen code
  function automatic int chk_w(int tag_w, bit sec);
    int r;
    if (!sec) return 1;
    r = 1;
    while ((1 << r) < tag_w + r + 1) r++;
    return r;
  endfunction

  function automatic int idx_w(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tag_guard_enc.sv
module tag_guard_enc #(
  parameter int TAG_W    = 20,
  parameter bit SEC_MODE = 1'b1,
  localparam int CHK_W   = tag_guard_pkg::chk_w(TAG_W, SEC_MODE),
  localparam int CW_W    = TAG_W + CHK_W
) (
  input  logic [TAG_W-1:0] tag_i,
  output logic [CW_W-1:0]  cw_o
);
  // tag bits covered by check bit j (data at non-power-of-two positions from 3)
  function automatic logic [TAG_W-1:0] cover_mask(int j);
    int pos;
    cover_mask = '0;
    pos = 2;
    for (int d = 0; d < TAG_W; d++) begin
      pos++;
      while ((pos & (pos - 1)) == 0) pos++;
      cover_mask[d] = pos[j];
    end
  endfunction

  logic [CHK_W-1:0] chk;

  if (SEC_MODE) begin : g_sec
    for (genvar j = 0; j < CHK_W; j++) begin : g_chk
      localparam logic [TAG_W-1:0] MASK = cover_mask(j);
      assign chk[j] = ^(tag_i & MASK);
    end
  end else begin : g_par
    assign chk = ^tag_i;
  end

  assign cw_o = {chk, tag_i};
endmodule

// File: rtl/tag_guard_way.sv
module tag_guard_way #(
  parameter int CW_W     = 25,
  parameter bit SEC_MODE = 1'b1
) (
  input  logic [CW_W-1:0] fresh_i,
  input  logic [CW_W-1:0] stored_i,
  input  logic            valid_i,
  output logic            hit_o,
  output logic            flip_o
);
  logic [CW_W-1:0] diff;
  logic            same, one_off;

  assign diff    = fresh_i ^ stored_i;
  assign same    = (diff == '0);
  assign one_off = $onehot(diff);

  assign hit_o  = valid_i & (same | (SEC_MODE & one_off));
  assign flip_o = valid_i & one_off;
endmodule

// File: rtl/tag_guard_cmp.sv
module tag_guard_cmp #(
  parameter int WAYS     = 4,
  parameter int TAG_W    = 20,
  parameter bit SEC_MODE = 1'b1,
  parameter bit OUT_REG  = 1'b1,
  localparam int CHK_W   = tag_guard_pkg::chk_w(TAG_W, SEC_MODE),
  localparam int CW_W    = TAG_W + CHK_W,
  localparam int IDX_W   = tag_guard_pkg::idx_w(WAYS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [TAG_W-1:0]           lookup_tag_i,
  input  logic [WAYS-1:0][CW_W-1:0]  way_cw_i,
  input  logic [WAYS-1:0]            valid_i,
  output logic [WAYS-1:0]            hit_vec_o,
  output logic                       hit_any_o,
  output logic [IDX_W-1:0]           hit_idx_o,
  output logic                       err_o
);
  logic [CW_W-1:0]  fresh;
  logic [WAYS-1:0]  hit_d, flip_d;
  logic [IDX_W-1:0] idx_d;
  logic             any_d, err_d;

  tag_guard_enc #(.TAG_W(TAG_W), .SEC_MODE(SEC_MODE)) enc_i (
    .tag_i (lookup_tag_i),
    .cw_o  (fresh)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tag_guard_way #(.CW_W(CW_W), .SEC_MODE(SEC_MODE)) way_i (
      .fresh_i  (fresh),
      .stored_i (way_cw_i[w]),
      .valid_i  (valid_i[w]),
      .hit_o    (hit_d[w]),
      .flip_o   (flip_d[w])
    );
  end

  // lowest way wins
  always_comb begin
    idx_d = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (hit_d[i]) idx_d = IDX_W'(i);
  end

  assign any_d = |hit_d;
  assign err_d = |flip_d;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hit_vec_o <= '0;
        hit_any_o <= 1'b0;
        hit_idx_o <= '0;
        err_o     <= 1'b0;
      end else begin
        hit_vec_o <= hit_d;
        hit_any_o <= any_d;
        hit_idx_o <= idx_d;
        err_o     <= err_d;
      end
    end
  end else begin : g_comb
    assign hit_vec_o = hit_d;
    assign hit_any_o = any_d;
    assign hit_idx_o = idx_d;
    assign err_o     = err_d;
  end
endmodule

// File: rtl/tag_guard_cmp_chk.sv
module tag_guard_cmp_chk #(
  parameter int WAYS    = 4,
  parameter int TAG_W   = 20,
  parameter int CW_W    = 25,
  parameter int IDX_W   = 2,
  parameter bit OUT_REG = 1'b1
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [TAG_W-1:0]          lookup_tag_i,
  input logic [WAYS-1:0][CW_W-1:0] way_cw_i,
  input logic [WAYS-1:0]           valid_i,
  input logic [WAYS-1:0]           hit_vec_o,
  input logic                      hit_any_o,
  input logic [IDX_W-1:0]          hit_idx_o,
  input logic                      err_o
);
  logic [WAYS-1:0] valid_q, vld_ref, low_mask;
  logic            armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      armed   <= 1'b0;
    end else begin
      valid_q <= valid_i;
      armed   <= 1'b1;
    end
  end

  assign vld_ref  = OUT_REG ? valid_q : valid_i;
  assign low_mask = (WAYS'(1) << hit_idx_o) - WAYS'(1);

  // R8
  idx_hits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_any_o |-> (hit_vec_o[hit_idx_o] && ((hit_vec_o & low_mask) == '0)));

  // R8
  no_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_any_o |-> (hit_vec_o == '0 && hit_idx_o == '0));

  // R7
  invalid_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_vec_o & ~vld_ref) == '0);

  // R7
  invalid_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (vld_ref != '0));

  if (OUT_REG) begin : g_lat
    // R9
    hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed && $stable(lookup_tag_i) && $stable(way_cw_i) && $stable(valid_i))
      |=> ($stable(hit_vec_o) && $stable(err_o) && $stable(hit_idx_o)));
  end
endmodule

bind tag_guard_cmp tag_guard_cmp_chk #(
  .WAYS(WAYS), .TAG_W(TAG_W), .CW_W(CW_W), .IDX_W(IDX_W), .OUT_REG(OUT_REG)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .lookup_tag_i(lookup_tag_i), .way_cw_i(way_cw_i),
  .valid_i(valid_i), .hit_vec_o(hit_vec_o), .hit_any_o(hit_any_o),
  .hit_idx_o(hit_idx_o), .err_o(err_o)
);

// File: tb/tag_guard_cmp_tb_top.sv
`timescale 1ns/1ps
module tag_guard_cmp_tb_top;
  localparam int WAYS  = 4;
  localparam int TAG_W = 20;
  localparam int R_S   = 5;
  localparam int CW_S  = TAG_W + R_S;
  localparam int CW_P  = TAG_W + 1;

  typedef struct packed {
    logic [19:0] tag;
    logic [1:0]  way;
    logic [5:0]  f1;   // 63 = no flip
    logic [5:0]  f2;
    logic [3:0]  vld;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{20'h12345, 2'd0, 6'd63, 6'd63, 4'hF},
    '{20'hABCDE, 2'd3, 6'd7,  6'd63, 4'hF},
    '{20'h00000, 2'd1, 6'd22, 6'd63, 4'hF},
    '{20'hFFFFF, 2'd2, 6'd3,  6'd11, 4'hF},
    '{20'h5A5A5, 2'd2, 6'd63, 6'd63, 4'b1011},
    '{20'h0F0F0, 2'd1, 6'd24, 6'd63, 4'b0010},
    '{20'h80001, 2'd3, 6'd20, 6'd63, 4'hF},
    '{20'h33333, 2'd0, 6'd5,  6'd63, 4'b1110}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [TAG_W-1:0] tag_in = '0;
  logic [WAYS-1:0]  vld_in = '0;
  logic [WAYS-1:0][CW_S-1:0] cw_s = '0;
  logic [WAYS-1:0][CW_P-1:0] cw_p = '0;
  logic [WAYS-1:0] s_vec, p_vec;
  logic s_any, p_any, s_err, p_err;
  logic [1:0] s_idx, p_idx;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  tag_guard_cmp dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .lookup_tag_i(tag_in), .way_cw_i(cw_s),
    .valid_i(vld_in), .hit_vec_o(s_vec), .hit_any_o(s_any), .hit_idx_o(s_idx),
    .err_o(s_err)
  );

  tag_guard_cmp #(.SEC_MODE(1'b0)) dut_par_i (
    .clk_i(clk), .rst_ni(rst_ni), .lookup_tag_i(tag_in), .way_cw_i(cw_p),
    .valid_i(vld_in), .hit_vec_o(p_vec), .hit_any_o(p_any), .hit_idx_o(p_idx),
    .err_o(p_err)
  );

  function automatic logic [CW_S-1:0] enc_sec(logic [TAG_W-1:0] t);
    logic [CW_S-1:0] c;
    int d;
    c = '0;
    c[TAG_W-1:0] = t;
    d = 0;
    for (int p = 1; p <= CW_S; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int j = 0; j < R_S; j++)
          if (p[j]) c[TAG_W+j] = c[TAG_W+j] ^ t[d];
        d++;
      end
    end
    return c;
  endfunction

  function automatic logic [CW_P-1:0] enc_par(logic [TAG_W-1:0] t);
    return {^t, t};
  endfunction

  task automatic check(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic check_all(logic [3:0] ev_s, logic ee_s, logic [3:0] ev_p, logic ee_p);
    logic [1:0] ei_s, ei_p;
    ei_s = 2'd0; ei_p = 2'd0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (ev_s[i]) ei_s = 2'(i);
      if (ev_p[i]) ei_p = 2'(i);
    end
    check("R1 R3 R6 R7 sec hit_vec", s_vec, ev_s);
    check("R8 sec hit_any", s_any, |ev_s);
    check("R8 sec hit_idx", s_idx, ei_s);
    check("R4 R6 R7 sec err", s_err, ee_s);
    check("R2 R5 R6 R7 par hit_vec", p_vec, ev_p);
    check("R8 par hit_any", p_any, |ev_p);
    check("R8 par hit_idx", p_idx, ei_p);
    check("R5 R6 R7 par err", p_err, ee_p);
  endtask

  // drive one lookup at a falling edge, check after the next rising edge
  task automatic run_case(logic [19:0] tag, int way, int f1, int f2, logic [3:0] vld, int dup);
    logic [CW_S-1:0] cs;
    logic [CW_P-1:0] cp;
    logic [19:0] other;
    logic [3:0] ev_s, ev_p;
    int nf;
    @(negedge clk);
    for (int w = 0; w < WAYS; w++) begin
      other = tag ^ 20'(20'h01111 * (w + 1));
      cw_s[w] = enc_sec(other);
      cw_p[w] = enc_par(other);
    end
    cs = enc_sec(tag);
    cp = enc_par(tag);
    if (dup >= 0) begin cw_s[dup] = cs; cw_p[dup] = cp; end
    nf = 0;
    if (f1 >= 0) begin cs[f1 % CW_S] = ~cs[f1 % CW_S]; cp[f1 % CW_P] = ~cp[f1 % CW_P]; nf++; end
    if (f2 >= 0) begin cs[f2 % CW_S] = ~cs[f2 % CW_S]; cp[f2 % CW_P] = ~cp[f2 % CW_P]; nf++; end
    cw_s[way] = cs;
    cw_p[way] = cp;
    tag_in = tag;
    vld_in = vld;
    ev_s = '0; ev_p = '0;
    if (vld[way] && nf <= 1) ev_s[way] = 1'b1;
    if (vld[way] && nf == 0) ev_p[way] = 1'b1;
    if (dup >= 0 && vld[dup]) begin ev_s[dup] = 1'b1; ev_p[dup] = 1'b1; end
    @(negedge clk);
    check_all(ev_s, vld[way] && nf == 1, ev_p, vld[way] && nf == 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R9 reset state: inputs that would hit, outputs must stay 0
    tag_in = 20'h12345;
    cw_s[0] = enc_sec(20'h12345);
    cw_p[0] = enc_par(20'h12345);
    vld_in = 4'hF;
    repeat (3) @(negedge clk);
    check("R9 reset hit_vec sec", s_vec, 0);
    check("R9 reset hit_vec par", p_vec, 0);
    check("R9 reset any/err", {s_any, s_err, p_any, p_err}, 0);
    rst_ni = 1'b1;

    foreach (VEC[k])
      run_case(VEC[k].tag, int'(VEC[k].way),
               (VEC[k].f1 == 6'd63) ? -1 : int'(VEC[k].f1),
               (VEC[k].f2 == 6'd63) ? -1 : int'(VEC[k].f2), VEC[k].vld, -1);

    // random single-bit faults: sec corrects, parity flags (R3 R4 R5)
    for (int n = 0; n < 24; n++)
      run_case(20'($urandom), int'($urandom % WAYS), int'($urandom % CW_S), -1, 4'hF, -1);

    // R8 duplicate tag on ways 1 and 2: lowest index wins
    run_case(20'h6789A, 2, -1, -1, 4'hF, 1);

    // R9 latency: new inputs not visible before the next rising edge
    run_case(20'h13579, 3, -1, -1, 4'hF, -1);
    @(negedge clk);
    vld_in = 4'h0;
    #1;
    check("R9 output holds before edge", s_vec, 4'b1000);
    @(negedge clk);
    check("R9 R7 output follows after edge", s_vec, 0);

    // R9 asynchronous reset clears a live hit
    run_case(20'h2468A, 0, -1, -1, 4'hF, -1);
    #1 rst_ni = 1'b0;
    #1;
    check("R9 async reset clears", {s_vec, p_vec, s_any, p_any}, 0);
    rst_ni = 1'b1;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule